// File: doc/BRIEF.md
# Self-Refresh Entry and Exit Sequencer

This block lives inside a memory controller for DDR2-style DRAM and takes charge of the low-power self-refresh mode. The controller pulses a request to go into self-refresh or to come out of it. The block then steps through the required sequence. On the way in, it turns ODT off, waits, and issues the self-refresh entry command with CKE low. On the way out, it waits for the clock to be reported stable and raises CKE. It then drives NOP until the shorter exit delay has run, and it issues the owed auto refresh itself.

Two post-exit timers gate the rest of the controller. `ready_o` enables ordinary commands once the shorter delay has run and the owed refresh has gone out. `rd_ready_o` enables reads once the longer delay has run. ODT and a new self-refresh entry are also held back until the longer delay has expired. Entry requests are latched and never dropped. The delays are given in clock cycles as module parameters.

Top module: `sr_sequencer`

## Requirements
- R1: After reset, cke_o is 1, cmd_o is NOP (2'd0), ready_o and rd_ready_o are 1, no refresh is owed, and odt_o equals odt_req_i.
- R2: A pulse on sr_enter_i is latched as pending and is not dropped. The entry sequence begins only in a cycle where the request is pending, banks_idle_i is 1, no refresh is owed and the read timer has expired.
- R3: The entry sequence drives odt_o to 0 for T_AOFD cycles with cke_o high and cmd_o NOP. It then drives cmd_o = SRE (2'd2) for one cycle with cke_o at 0. After that cke_o stays 0 and cmd_o stays NOP.
- R4: A pulse on sr_exit_i has an effect only while the block is in self-refresh; at any other time it is ignored. A latched exit raises cke_o in the first cycle after a cycle that has both the pending exit and clk_stable_i at 1.
- R5: Once cke_o rises, it stays high for at least T_XSRD cycles.
- R6: Counting the first cycle with CKE high as cycle 0, cmd_o is NOP in cycles 0 to T_XSNR-1. In cycle T_XSNR, the block issues exactly one auto refresh (cmd_o = 2'd1).
- R7: After an exit, ready_o rises in cycle T_XSNR+1. rd_ready_o rises in the later of cycles T_XSRD and T_XSNR+1.
- R8: After an exit, odt_o is held at 0 until cycle T_XSRD. From then on it follows odt_req_i while the block is active.
- R9: A new self-refresh entry cannot begin until the owed auto refresh has been issued and T_XSRD has expired. A request made during that time is served as soon as both conditions hold.
- R10: ready_o and rd_ready_o are 0 throughout the entry sequence and self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sr_enter_i | input | 1 | Pulse requesting self-refresh entry |
| sr_exit_i | input | 1 | Pulse requesting self-refresh exit |
| banks_idle_i | input | 1 | All banks are idle |
| clk_stable_i | input | 1 | DRAM clock is stable |
| odt_req_i | input | 1 | ODT requested by the controller |
| cke_o | output | 1 | Clock enable to the DRAM |
| odt_o | output | 1 | On-die termination enable |
| cmd_o | output | 2 | 0 NOP, 1 auto refresh, 2 self-refresh entry |
| ready_o | output | 1 | Non-read commands permitted |
| rd_ready_o | output | 1 | Read commands permitted |

## Verification
Two events can land in the same cycle: the owed auto refresh after an exit, and a new entry request. The bench times an entry pulse to arrive exactly in the cycle where the block issues its refresh. It then checks that the request stays pending and that entry starts only after T_XSRD has expired. A behavioural reference model predicts every output on every clock, and each mismatch is reported against its requirement.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_AREF = 2'd1,
    CMD_SRE  = 2'd2
  } sr_cmd_e;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_ODTOFF = 2'd1,
    ST_ENTER  = 2'd2,
    ST_SREF   = 2'd3
  } sr_state_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sr_dn_counter.sv
module sr_dn_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sr_fsm.sv
module sr_fsm
  import sr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sr_enter_i,
  input  logic       sr_exit_i,
  input  logic       banks_idle_i,
  input  logic       clk_stable_i,
  input  logic       odt_req_i,
  input  logic       aofd_zero_i,
  input  logic       xsnr_zero_i,
  input  logic       xsrd_zero_i,
  output logic       aofd_load_o,
  output logic       exit_load_o,
  output logic       cke_o,
  output logic       odt_o,
  output logic [1:0] cmd_o,
  output logic       ready_o,
  output logic       rd_ready_o
);
  sr_state_e st_q, st_d;
  logic enter_pend_q, exit_pend_q, owed_q;
  logic act, go, rise, aref;

  assign act  = (st_q == ST_ACTIVE);
  assign aref = act && owed_q && xsnr_zero_i;
  assign go   = act && enter_pend_q && banks_idle_i && !owed_q && xsrd_zero_i;
  assign rise = (st_q == ST_SREF) && exit_pend_q && clk_stable_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_ACTIVE: if (go) st_d = ST_ODTOFF;
      ST_ODTOFF: if (aofd_zero_i) st_d = ST_ENTER;
      ST_ENTER:  st_d = ST_SREF;
      ST_SREF:   if (rise) st_d = ST_ACTIVE;
      default:   st_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_ACTIVE;
      enter_pend_q <= 1'b0;
      exit_pend_q  <= 1'b0;
      owed_q       <= 1'b0;
    end else begin
      st_q         <= st_d;
      // a request seen in the entry cycle stays pending for a later entry
      enter_pend_q <= (enter_pend_q && (st_q != ST_ENTER)) || sr_enter_i;
      exit_pend_q  <= (exit_pend_q || (sr_exit_i && (st_q == ST_SREF))) && !rise;
      if (rise)      owed_q <= 1'b1;
      else if (aref) owed_q <= 1'b0;
    end
  end

  assign aofd_load_o = go;
  assign exit_load_o = rise;
  assign cke_o       = act || (st_q == ST_ODTOFF);
  assign odt_o       = odt_req_i && act && xsrd_zero_i;
  assign ready_o     = act && xsnr_zero_i && !owed_q;
  assign rd_ready_o  = act && xsrd_zero_i && !owed_q;

  always_comb begin
    if (st_q == ST_ENTER) cmd_o = CMD_SRE;
    else if (aref)        cmd_o = CMD_AREF;
    else                  cmd_o = CMD_NOP;
  end
endmodule

// File: rtl/sr_sequencer.sv
module sr_sequencer
  import sr_pkg::*;
#(
  parameter int T_AOFD = 3,
  parameter int T_XSNR = 8,
  parameter int T_XSRD = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sr_enter_i,
  input  logic       sr_exit_i,
  input  logic       banks_idle_i,
  input  logic       clk_stable_i,
  input  logic       odt_req_i,
  output logic       cke_o,
  output logic       odt_o,
  output logic [1:0] cmd_o,
  output logic       ready_o,
  output logic       rd_ready_o
);
  localparam int CW = $clog2(max3(T_AOFD, T_XSNR, T_XSRD) + 1);
  localparam int EXIT_T [2] = '{T_XSNR, T_XSRD};

  logic aofd_load, exit_load, aofd_zero;
  logic [1:0] exit_zero;

  sr_dn_counter #(.W(CW)) u_aofd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (aofd_load),
    .load_val_i (CW'(T_AOFD - 1)),
    .zero_o     (aofd_zero)
  );

  // index 0: non-read exit timer, index 1: read exit timer
  for (genvar g = 0; g < 2; g++) begin : g_exit_tmr
    sr_dn_counter #(.W(CW)) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (exit_load),
      .load_val_i (CW'(EXIT_T[g])),
      .zero_o     (exit_zero[g])
    );
  end

  sr_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sr_enter_i   (sr_enter_i),
    .sr_exit_i    (sr_exit_i),
    .banks_idle_i (banks_idle_i),
    .clk_stable_i (clk_stable_i),
    .odt_req_i    (odt_req_i),
    .aofd_zero_i  (aofd_zero),
    .xsnr_zero_i  (exit_zero[0]),
    .xsrd_zero_i  (exit_zero[1]),
    .aofd_load_o  (aofd_load),
    .exit_load_o  (exit_load),
    .cke_o        (cke_o),
    .odt_o        (odt_o),
    .cmd_o        (cmd_o),
    .ready_o      (ready_o),
    .rd_ready_o   (rd_ready_o)
  );
endmodule

// File: rtl/sr_sequencer_chk.sv
module sr_sequencer_chk #(
  parameter int T_AOFD = 3,
  parameter int T_XSNR = 8,
  parameter int T_XSRD = 20
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_stable_i,
  input logic       cke_o,
  input logic       odt_o,
  input logic [1:0] cmd_o,
  input logic       ready_o,
  input logic       rd_ready_o
);
  localparam logic [15:0] SAT = 16'(T_XSRD);

  logic        cke_q, aref_seen_q;
  logic [15:0] since_q, since_now, low_q;
  logic        rise;

  assign rise      = cke_o && !cke_q;
  assign since_now = rise ? 16'd0 : since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q       <= 1'b1;
      since_q     <= SAT;
      low_q       <= 16'hFFFF;
      aref_seen_q <= 1'b1;
    end else begin
      cke_q   <= cke_o;
      since_q <= (since_now >= SAT) ? SAT : since_now + 16'd1;
      low_q   <= odt_o ? 16'd0 : ((low_q == 16'hFFFF) ? low_q : low_q + 16'd1);
      if (rise)              aref_seen_q <= 1'b0;
      else if (cmd_o == 2'd1) aref_seen_q <= 1'b1;
    end
  end

  assert_odt_lead_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 2'd2) |-> (low_q >= 16'(T_AOFD) && !cke_o));
  assert_cke_rise_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> $past(clk_stable_i));
  assert_cke_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (since_now >= SAT));
  assert_exit_nop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_now < 16'(T_XSNR)) |-> (cmd_o == 2'd0));
  assert_ready_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (since_now >= 16'(T_XSNR)));
  assert_rd_ready_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_o |-> (since_now >= SAT));
  assert_odt_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odt_o |-> (since_now >= SAT));
  assert_reentry_refresh_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == 2'd2) |-> aref_seen_q);
  assert_no_ready_low_cke_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (!ready_o && !rd_ready_o));
endmodule

bind sr_sequencer sr_sequencer_chk #(
  .T_AOFD(T_AOFD), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clk_stable_i (clk_stable_i),
  .cke_o        (cke_o),
  .odt_o        (odt_o),
  .cmd_o        (cmd_o),
  .ready_o      (ready_o),
  .rd_ready_o   (rd_ready_o)
);

// File: tb/sr_sequencer_tb_top.sv
module sr_sequencer_tb_top;
  localparam int T_AOFD = 3;
  localparam int T_XSNR = 8;
  localparam int T_XSRD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_enter = 0, sr_exit = 0, banks_idle = 0, clk_stable = 0, odt_req = 0;
  logic cke, odt, ready, rd_ready;
  logic [1:0] cmd;

  int n_vec = 0, n_err = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sr_sequencer #(.T_AOFD(T_AOFD), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sr_enter_i(sr_enter), .sr_exit_i(sr_exit),
    .banks_idle_i(banks_idle), .clk_stable_i(clk_stable), .odt_req_i(odt_req),
    .cke_o(cke), .odt_o(odt), .cmd_o(cmd), .ready_o(ready), .rd_ready_o(rd_ready)
  );

  // behavioural reference: mode 0 active, 1 odt-off lead, 2 entry cmd, 3 self-refresh
  int m_mode, m_lead, m_since;
  bit m_owed, m_enter, m_exit;

  function automatic bit exp_aref();
    return m_mode == 0 && m_owed && m_since >= T_XSNR;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_lead = 0; m_since = T_XSRD;
      m_owed = 0; m_enter = 0; m_exit = 0;
    end else begin
      bit rise_now, go_now, aref_now;
      rise_now = (m_mode == 3) && m_exit && clk_stable;
      aref_now = exp_aref();
      go_now   = (m_mode == 0) && m_enter && banks_idle && !m_owed && m_since >= T_XSRD;
      m_enter  = (m_enter && m_mode != 2) || sr_enter;
      m_exit   = (m_exit || (sr_exit && m_mode == 3)) && !rise_now;
      if (m_since < T_XSRD) m_since++;
      case (m_mode)
        0: begin
          if (aref_now) m_owed = 0;
          if (go_now) begin m_mode = 1; m_lead = T_AOFD; end
        end
        1: begin m_lead--; if (m_lead == 0) m_mode = 2; end
        2: m_mode = 3;
        default: if (rise_now) begin m_mode = 0; m_since = 0; m_owed = 1; end
      endcase
    end
  end

  task automatic cmp(string req, string nm, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, nm, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      bit act_m;
      act_m = (m_mode == 0);
      cmp("R5", "cke", int'(cke), int'(m_mode <= 1));
      cmp("R6", "cmd", int'(cmd), (m_mode == 2) ? 2 : (exp_aref() ? 1 : 0));
      cmp("R7", "ready", int'(ready), int'(act_m && m_since >= T_XSNR && !m_owed));
      cmp("R7", "rd_ready", int'(rd_ready), int'(act_m && m_since >= T_XSRD && !m_owed));
      cmp("R8", "odt", int'(odt), int'(odt_req && act_m && m_since >= T_XSRD));
    end
    if (cyc > 5000 && !done) begin
      done = 1;
      n_err++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2;
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1: reset state
    cmp("R1", "reset cke", int'(cke), 1);
    cmp("R1", "reset ready", int'(ready), 1);
    cmp("R1", "reset rd_ready", int'(rd_ready), 1);
    cmp("R1", "reset cmd", int'(cmd), 0);
    cmp("R1", "reset odt", int'(odt), 0);
    odt_req = 1; tick(3); odt_req = 0; tick(1);
    // R4: exit pulse outside self-refresh has no effect
    sr_exit = 1; tick(1); sr_exit = 0; tick(3);
    cmp("R4", "stray exit cke", int'(cke), 1);
    // R2: entry held while banks busy
    odt_req = 1;
    sr_enter = 1; tick(1); sr_enter = 0; tick(10);
    cmp("R2", "held entry cke", int'(cke), 1);
    banks_idle = 1; tick(12);
    // R3: now in self-refresh
    cmp("R3", "in sr cke", int'(cke), 0);
    cmp("R10", "in sr ready", int'(ready), 0);
    // R4: exit waits for stable clock
    sr_exit = 1; tick(1); sr_exit = 0; tick(6);
    cmp("R4", "unstable clk cke", int'(cke), 0);
    clk_stable = 1; tick(4);
    // R9: entry request while refresh is owed
    sr_enter = 1; tick(1); sr_enter = 0; tick(50);
    cmp("R9", "reentered cke", int'(cke), 0);
    // collision: entry pulse in the refresh cycle
    sr_exit = 1; tick(1); sr_exit = 0; tick(9);
    sr_enter = 1; tick(1); sr_enter = 0; tick(3);
    cmp("R9", "pending after aref cke", int'(cke), 1);
    tick(40);
    cmp("R9", "second reentry cke", int'(cke), 0);
    sr_exit = 1; tick(1); sr_exit = 0; tick(30);
    cmp("R7", "final rd_ready", int'(rd_ready), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule